// File: doc/BRIEF.md
# Fully Associative Recency-Stack Tag Store

This block holds the tags of a small fully associative cache. Every entry sits in one slot of a recency stack, which runs from the most recently used entry at position 0 to the least recently used entry at position N-1. The tag is the block address, which is the request address with the low log2(block bytes) offset bits dropped. There is a single set, so the whole tag identifies a block.

Because a smaller LRU cache always holds the top slots of the same stack, a single lookup also tells whether that address would have hit in a cache of BASE, 2·BASE, 4·BASE, … entries. The block reports this as a residency mask on each response. For demand accesses it keeps a hit counter and a miss counter for every tracked capacity, up to and including the full store.

Requests travel on a valid/ready channel and responses return on a second valid/ready channel. A request is taken when `req_valid && req_ready`. Its response is registered and appears on the next cycle. `req_ready` is low only while an earlier response is still waiting for `rsp_ready`, so back-pressure on the response side stalls the request side in the same cycle. A response is held unchanged until it is consumed.

Top module: `fa_lru_tags`

## Requirements
- R1: Lookups compare only address bits [ADDR_W-1:log2(BLOCK_BYTES)]. Two addresses that differ only in their offset bits find the same entry.
- R2: After reset no entry is valid, entry p sits at stack position p (so entry N-1 is the first victim), every counter is 0 and `rsp_valid` is 0.
- R3: `req_ready` equals `!rsp_valid || rsp_ready`. A taken request gives `rsp_valid` high on the next cycle. While `rsp_valid && !rsp_ready`, every response field is held stable.
- R4: An ACCESS (`req_op` = 0) that hits returns `rsp_hit`=1 and `rsp_idx` = the entry, and moves that entry to position 0. The entries that were above it each move down one position. A miss returns `rsp_hit`=0 and `rsp_idx`=0 and leaves the stack unchanged.
- R5: A PROBE (`req_op` = 1) returns hit, index and mask exactly as an ACCESS would. It changes neither the stack order nor any counter.
- R6: `rsp_mask` bit i is 1 exactly when the request hit and the entry's stack position before the request was below BASE_ENTRIES·2^i. On a miss the mask is all zero.
- R7: A FILL (`req_op` = 2) of an absent tag writes the tag into the LRU entry, marks it valid, moves it to position 0, and returns `rsp_hit`=0 with `rsp_idx` = that entry. A FILL of a tag that is already present returns `rsp_hit`=1 and only promotes that entry, so no tag is ever held twice.
- R8: An INVAL (`req_op` = 3) that finds its tag clears the entry's valid bit and moves the entry to position N-1. An invalid entry never hits.
- R9: Each accepted ACCESS adds 1 to `acc_cnt`. For each capacity k (BASE_ENTRIES·2^k entries, k = 0..NCAP-1, where the last capacity is the full store), it adds 1 to hit counter k if the access hit at a position below that capacity, and otherwise adds 1 to miss counter k. No other op changes the counters.
- R10: `rsp_victim` reports, for every op, the entry that held position N-1 before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 access, 1 probe, 2 fill, 3 invalidate |
| req_addr | input | ADDR_W | Byte address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_hit | output | 1 | Tag found in a valid entry |
| rsp_idx | output | IDX_W | Hit entry, or allocated entry on a fill miss |
| rsp_victim | output | IDX_W | LRU entry before the request |
| rsp_mask | output | NCAP-1 | Residency in each smaller capacity |
| acc_cnt | output | CNT_W | Demand access count |
| hit_cnt | output | NCAP·CNT_W | Per-capacity hit counts, capacity k at bits [k·CNT_W +: CNT_W] |
| miss_cnt | output | NCAP·CNT_W | Per-capacity miss counts, same layout |

## Verification
Two things can happen on one clock edge. A pending response can be consumed, and a new request can be accepted, and that new request must see the stack as the previous request left it. The bench makes this happen by holding requests valid while it randomly drops and raises `rsp_ready`, so the promotions, demotions and fills that follow each other closely land on the edges where a stalled response is released. A reference model is advanced only on the edges where the request handshake completes. Each response is compared with that model on every cycle it is presented, held or new, and the counters are compared every cycle.

// File: rtl/fa_lru_pkg.sv
package fa_lru_pkg;
  typedef enum logic [1:0] {
    OP_ACCESS = 2'd0,
    OP_PROBE  = 2'd1,
    OP_FILL   = 2'd2,
    OP_INVAL  = 2'd3
  } op_e;
endpackage

// File: rtl/fa_lru_tag_array.sv
module fa_lru_tag_array #(
  parameter int N_ENTRIES = 16,
  parameter int TAG_W     = 28,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic [IDX_W-1:0] look_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  logic [N_ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [N_ENTRIES-1:0]            vld_q;
  logic [N_ENTRIES-1:0]            match;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    assign match[e] = vld_q[e] && (tag_q[e] == look_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[e] <= '0;
        vld_q[e] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        tag_q[e] <= wr_tag;
        vld_q[e] <= 1'b1;
      end else if (clr_en && clr_idx == IDX_W'(e)) begin
        vld_q[e] <= 1'b0;
      end
    end
  end

  always_comb begin
    look_idx = '0;
    for (int e = N_ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) look_idx = IDX_W'(e);
    end
  end
  assign look_hit = |match;

  // a fill never duplicates a present tag, so at most one entry matches
  p_unique_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/fa_lru_stack.sv
module fa_lru_stack #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] q_idx,
  output logic [IDX_W-1:0] q_pos,
  output logic [IDX_W-1:0] lru_idx,
  input  logic             mv_en,
  input  logic             mv_demote,
  input  logic [IDX_W-1:0] mv_idx,
  input  logic [IDX_W-1:0] mv_pos
);
  logic [N_ENTRIES-1:0][IDX_W-1:0] order_q, order_d;

  always_comb begin
    q_pos = '0;
    for (int p = 0; p < N_ENTRIES; p++) begin
      if (order_q[p] == q_idx) q_pos = IDX_W'(p);
    end
  end
  assign lru_idx = order_q[N_ENTRIES-1];

  always_comb begin
    order_d = order_q;
    if (mv_en && !mv_demote) begin
      order_d[0] = mv_idx;
      for (int q = 1; q < N_ENTRIES; q++) begin
        if (IDX_W'(q) <= mv_pos) order_d[q] = order_q[q-1];
      end
    end else if (mv_en) begin
      for (int q = 0; q < N_ENTRIES - 1; q++) begin
        if (IDX_W'(q) >= mv_pos) order_d[q] = order_q[q+1];
      end
      order_d[N_ENTRIES-1] = mv_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_ENTRIES; p++) order_q[p] <= IDX_W'(p);
    end else begin
      order_q <= order_d;
    end
  end

  logic [N_ENTRIES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < N_ENTRIES; p++) seen[order_q[p]] = 1'b1;
  end

  p_perm_r2:  assert property (@(posedge clk) disable iff (!rst_n) seen == {N_ENTRIES{1'b1}});
  p_head_r4:  assert property (@(posedge clk) disable iff (!rst_n)
                mv_en && !mv_demote |=> order_q[0] == $past(mv_idx));
  p_tail_r8:  assert property (@(posedge clk) disable iff (!rst_n)
                mv_en && mv_demote |=> order_q[N_ENTRIES-1] == $past(mv_idx));
  p_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !mv_en |=> $stable(order_q));
endmodule

// File: rtl/fa_lru_counters.sv
module fa_lru_counters #(
  parameter int NCAP  = 4,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic [NCAP-1:0]       cap_hit,
  output logic [CNT_W-1:0]      acc_cnt,
  output logic [NCAP*CNT_W-1:0] hit_cnt,
  output logic [NCAP*CNT_W-1:0] miss_cnt
);
  logic [CNT_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_q + 1'b1;
  end
  assign acc_cnt = acc_q;

  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    logic [CNT_W-1:0] hit_q, miss_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q  <= '0;
        miss_q <= '0;
      end else if (acc_en) begin
        if (cap_hit[k]) hit_q  <= hit_q + 1'b1;
        else            miss_q <= miss_q + 1'b1;
      end
    end
    assign hit_cnt[k*CNT_W +: CNT_W]  = hit_q;
    assign miss_cnt[k*CNT_W +: CNT_W] = miss_q;

    p_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
                CNT_W'(hit_q + miss_q) == acc_q);
  end
endmodule

// File: rtl/fa_lru_tags.sv
module fa_lru_tags
  import fa_lru_pkg::*;
#(
  parameter int N_ENTRIES    = 16,
  parameter int BASE_ENTRIES = 2,
  parameter int ADDR_W       = 32,
  parameter int BLOCK_BYTES  = 16,
  parameter int CNT_W        = 16,
  localparam int IDX_W       = $clog2(N_ENTRIES),
  localparam int OFF_W       = $clog2(BLOCK_BYTES),
  localparam int TAG_W       = ADDR_W - OFF_W,
  localparam int NCAP        = $clog2(N_ENTRIES / BASE_ENTRIES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit,
  output logic [IDX_W-1:0]      rsp_idx,
  output logic [IDX_W-1:0]      rsp_victim,
  output logic [NCAP-2:0]       rsp_mask,
  output logic [CNT_W-1:0]      acc_cnt,
  output logic [NCAP*CNT_W-1:0] hit_cnt,
  output logic [NCAP*CNT_W-1:0] miss_cnt
);
  op_e              op;
  logic             fire;
  logic [TAG_W-1:0] look_tag;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx, lk_pos, lru_idx;
  logic [NCAP-1:0]  cap_hit;
  logic             fill_alloc, inval_hit;
  logic             mv_en, mv_demote;
  logic [IDX_W-1:0] mv_idx, mv_pos;

  assign op        = op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign look_tag  = req_addr[ADDR_W-1:OFF_W];

  fa_lru_tag_array #(.N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_tag (look_tag),
    .look_hit (lk_hit),
    .look_idx (lk_idx),
    .wr_en    (fire && fill_alloc),
    .wr_idx   (lru_idx),
    .wr_tag   (look_tag),
    .clr_en   (fire && inval_hit),
    .clr_idx  (lk_idx)
  );

  fa_lru_stack #(.N_ENTRIES(N_ENTRIES)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_idx     (lk_idx),
    .q_pos     (lk_pos),
    .lru_idx   (lru_idx),
    .mv_en     (mv_en),
    .mv_demote (mv_demote),
    .mv_idx    (mv_idx),
    .mv_pos    (mv_pos)
  );

  // residency per capacity, judged on the position before this request moves it
  for (genvar k = 0; k < NCAP; k++) begin : g_res
    assign cap_hit[k] = lk_hit && (32'(lk_pos) < (BASE_ENTRIES << k));
  end

  assign fill_alloc = (op == OP_FILL) && !lk_hit;
  assign inval_hit  = (op == OP_INVAL) && lk_hit;
  assign mv_en      = fire && (((op == OP_ACCESS || op == OP_FILL) && lk_hit) ||
                               fill_alloc || inval_hit);
  assign mv_demote  = inval_hit;
  assign mv_idx     = fill_alloc ? lru_idx : lk_idx;
  assign mv_pos     = fill_alloc ? IDX_W'(N_ENTRIES - 1) : lk_pos;

  fa_lru_counters #(.NCAP(NCAP), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (fire && op == OP_ACCESS),
    .cap_hit  (cap_hit),
    .acc_cnt  (acc_cnt),
    .hit_cnt  (hit_cnt),
    .miss_cnt (miss_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_idx    <= '0;
      rsp_victim <= '0;
      rsp_mask   <= '0;
    end else if (fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= lk_hit;
      rsp_idx    <= fill_alloc ? lru_idx : lk_idx;
      rsp_victim <= lru_idx;
      rsp_mask   <= cap_hit[NCAP-2:0];
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
               rsp_valid && !rsp_ready |=> rsp_valid &&
               $stable({rsp_hit, rsp_idx, rsp_victim, rsp_mask}));
  p_miss_nomask_r6: assert property (@(posedge clk) disable iff (!rst_n)
               rsp_valid && !rsp_hit |-> rsp_mask == '0);
  for (genvar i = 0; i < NCAP - 2; i++) begin : g_mono
    p_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
                 rsp_valid && rsp_mask[i] |-> rsp_mask[i+1]);
  end
endmodule

// File: tb/fa_lru_tags_tb.sv
`timescale 1ns/1ps
module fa_lru_tags_tb_top;
  localparam int N     = 16;
  localparam int BASE  = 2;
  localparam int NCAP  = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic rsp_ready = 1'b0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [3:0] rsp_idx, rsp_victim;
  logic [NCAP-2:0] rsp_mask;
  logic [CNT_W-1:0] acc_cnt;
  logic [NCAP*CNT_W-1:0] hit_cnt, miss_cnt;

  always #2.5 clk = ~clk;

  fa_lru_tags dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_victim(rsp_victim), .rsp_mask(rsp_mask), .acc_cnt(acc_cnt),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  int m_tag[N];
  bit m_vld[N];
  int m_ord[N];
  int m_acc, m_hit[NCAP], m_miss[NCAP];
  bit exp_rv;
  int p_op, p_hit, p_idx, p_vic, p_mask;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int find_tag(int tg);
    for (int e = 0; e < N; e++) if (m_vld[e] && m_tag[e] == tg) return e;
    return -1;
  endfunction

  function automatic int pos_of(int e);
    for (int p = 0; p < N; p++) if (m_ord[p] == e) return p;
    return 0;
  endfunction

  task automatic promote(int e, int p);
    for (int q = p; q > 0; q--) m_ord[q] = m_ord[q-1];
    m_ord[0] = e;
  endtask

  task automatic demote(int e, int p);
    for (int q = p; q < N - 1; q++) m_ord[q] = m_ord[q+1];
    m_ord[N-1] = e;
  endtask

  task automatic model_reset();
    for (int e = 0; e < N; e++) begin m_tag[e] = 0; m_vld[e] = 0; m_ord[e] = e; end
    m_acc = 0;
    for (int k = 0; k < NCAP; k++) begin m_hit[k] = 0; m_miss[k] = 0; end
    exp_rv = 0;
  endtask

  task automatic model_apply(int op, logic [31:0] a);
    int tg, f, pos, lru;
    tg = int'(a >> 4);
    f = find_tag(tg);
    lru = m_ord[N-1];
    pos = (f >= 0) ? pos_of(f) : 0;
    p_op = op; p_vic = lru; p_hit = (f >= 0); p_idx = (f >= 0) ? f : 0;
    p_mask = 0;
    if (f >= 0)
      for (int i = 0; i < NCAP - 1; i++) if (pos < (BASE << i)) p_mask |= (1 << i);
    case (op)
      0: begin
        m_acc++;
        for (int k = 0; k < NCAP; k++)
          if (f >= 0 && pos < (BASE << k)) m_hit[k]++; else m_miss[k]++;
        if (f >= 0) promote(f, pos);
      end
      2: begin
        if (f >= 0) promote(f, pos);
        else begin
          m_tag[lru] = tg; m_vld[lru] = 1; promote(lru, N - 1); p_idx = lru;
        end
      end
      3: if (f >= 0) begin m_vld[f] = 0; demote(f, pos); end
      default: ;
    endcase
  endtask

  function automatic string op_req(int op);
    case (op)
      0: return "R4 R1";
      1: return "R5";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_outputs();
    chk("R3 rsp_valid", int'(rsp_valid), int'(exp_rv));
    if (exp_rv && rsp_valid) begin
      chk({op_req(p_op), " hit"}, int'(rsp_hit), p_hit);
      chk({op_req(p_op), " idx"}, int'(rsp_idx), p_idx);
      chk("R10 victim", int'(rsp_victim), p_vic);
      chk("R6 mask", int'(rsp_mask), p_mask);
    end
    chk("R9 acc_cnt", int'(acc_cnt), m_acc & 16'hffff);
    for (int k = 0; k < NCAP; k++) begin
      chk("R9 hit_cnt", int'(hit_cnt[k*CNT_W +: CNT_W]), m_hit[k] & 16'hffff);
      chk("R9 miss_cnt", int'(miss_cnt[k*CNT_W +: CNT_W]), m_miss[k] & 16'hffff);
    end
  endtask

  // one cycle, entered and left at a falling edge
  task automatic cycle(bit v, int op, logic [31:0] a, bit rr);
    bit acc, nxt;
    req_valid = v; req_op = 2'(op); req_addr = a; rsp_ready = rr;
    #1;
    chk("R3 req_ready", int'(req_ready), int'(!exp_rv || rr));
    acc = v && req_ready;
    if (acc) model_apply(op, a);
    nxt = acc ? 1'b1 : (exp_rv && !rr);
    @(posedge clk);
    @(negedge clk);
    exp_rv = nxt;
    check_outputs();
  endtask

  function automatic logic [31:0] mk(int tg, int off);
    return ((32'h100 + 32'(tg)) << 4) | 32'(off & 15);
  endfunction

  task automatic req(int op, int tg, int off);
    cycle(1'b1, op, mk(tg, off), 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed, op, r;
    seed = 32'h5eed;
    void'($urandom(seed));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk("R2 rsp_valid", int'(rsp_valid), 0);
    chk("R2 req_ready", int'(req_ready), 1);
    chk("R2 acc_cnt", int'(acc_cnt), 0);
    chk("R2 hit_cnt", int'(hit_cnt), 0);
    req(1, 0, 0);                        // R2 R8: empty store never hits
    for (int t = 0; t < N; t++) req(2, t, t);  // R7 fills, R10 victims 15,14,...
    req(2, 0, 9);                        // R7 refresh of present tag
    req(0, 1, 3);                        // R4 deep hit, full capacity only
    req(0, 1, 12);                       // R1 other offset, now at MRU
    req(0, 14, 0);                       // R6 mid-stack position
    req(1, 5, 0);                        // R5 probe leaves order
    req(0, 5, 0);
    req(3, 3, 0);                        // R8 invalidate, demote to LRU
    req(0, 3, 0);                        // R8 invalid entry misses
    req(2, 30, 0);                       // R8 R10 demoted entry is the victim
    // R3 stall: response held, next request not taken
    cycle(1'b1, 0, mk(2, 0), 1'b0);
    cycle(1'b1, 0, mk(4, 0), 1'b0);
    cycle(1'b1, 0, mk(4, 0), 1'b0);
    cycle(1'b1, 0, mk(4, 0), 1'b1);
    cycle(1'b0, 0, 32'h0, 1'b1);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      r = int'($urandom_range(0, 99));
      op = (r < 50) ? 0 : (r < 65) ? 1 : (r < 90) ? 2 : 3;
      cycle($urandom_range(0, 9) < 8, op,
            mk(int'($urandom_range(0, 23)), int'($urandom_range(0, 15))),
            $urandom_range(0, 3) != 0);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule